// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

The block walks a key matrix of eight row lines by up to seven column bits, one row at a time, each time it is given a start strobe. It keeps a map holding the last accepted state of every row. At the start of a scan a reset strobe clears the row counter. After that, a step strobe moves the counter on to each following row. A row line is pulled low only for a short drive window after a reset or step strobe. At the end of that window the column inputs are sampled and inverted.

A row whose reading equals its map entry costs no extra time. A row whose reading differs waits out a debounce interval, then is driven and read a second time. The change is accepted only when both readings agree. On acceptance the block updates the map entry and emits a one-cycle event carrying the row index, the mask of keys that changed and the new row state. A done pulse closes every scan, along with a flag that tells whether any change was accepted. A parameter masks off the top column bit for a six-column matrix.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset, `busy`, `done` and `evtValid` are 0, every `rowDriveN` bit is 1, and every map entry is zero, which means no key is pressed.
- R2: A column input at 0 means a pressed key and is captured as 1. `evtState` bit c is 1 when the key at column c of the event row is pressed. `evtMask` is the XOR of the accepted reading and the previous map entry.
- R3: `rowDriveN` has at most one bit low, and only inside a drive window of `DRIVE_CYCLES` cycles. Rows are visited in ascending order from 0 to `NUM_ROWS`-1, and the scan starts again from row 0 on every start.
- R4: A scan in which no row differs from the map lasts exactly 1 + NUM_ROWS*(DRIVE_CYCLES+1) + (NUM_ROWS-1) + 1 busy cycles, the done cycle included. No debounce wait is inserted.
- R5: Each row that differs from its map entry adds exactly DEBOUNCE_CYCLES + DRIVE_CYCLES + 1 cycles for the wait, the second read and the decision. If both readings agree, one event is emitted for that row and its map entry takes the new value, so a repeat scan with the same keys gives no event.
- R6: If the second reading of a differing row disagrees with the first, no event is emitted and the map entry keeps its old value. The next scan therefore reports the change again.
- R7: `done` is high for exactly one cycle, the last busy cycle. In that cycle `keyEvent` is 1 only if at least one event was emitted during that scan.
- R8: A start strobe while `busy` is high is ignored. The scan running at the time keeps its length and its events.
- R9: With `USED_COLS` = 6, the top column bit never shows in a reading, a mask or a state. A key present only in that column produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan when the block is idle |
| colsN | input | NUM_COLS | Column sense lines, active low |
| rowDriveN | output | NUM_ROWS | Row drive lines, one-hot active low within drive windows |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse at the end of a scan |
| keyEvent | output | 1 | Qualified by `done`: at least one change was accepted in the scan |
| evtValid | output | 1 | One-cycle event strobe |
| evtRow | output | $clog2(NUM_ROWS) | Row index of the event |
| evtMask | output | NUM_COLS | Keys that changed in the event row |
| evtState | output | NUM_COLS | New pressed state of the event row |

## Verification
`busy` rises one cycle after an accepted start. The done cycle falls at a length the bench computes in closed form from the rows that differ from its own map model: the base length plus DEBOUNCE_CYCLES + DRIVE_CYCLES + 1 for each differing row. An event appears in the cycle after the second read of its row, so it is always seen before `done` falls. The bench drives on falling edges and samples on falling edges. It counts busy cycles one per falling edge until `done` is seen, checks `keyEvent` in that same cycle, and checks `busy` and `done` low one cycle later. A bench model drives the columns from `rowDriveN` and may flip bits on the second drive window of a chosen row to produce bounce.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

  // Strobes from the sequencer to the datapath, one cycle each unless noted
  typedef struct packed {
    logic rowReset;  // force row counter to zero
    logic rowStep;   // advance row counter by one
    logic driveOn;   // level: drive the selected row low
    logic captureA;  // sample first reading
    logic captureB;  // sample confirming reading
    logic commit;    // accept change if both readings agree
    logic clrFlag;   // clear per-scan event flag
  } scan_ctrl_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET,
    ST_DRIVE_A,
    ST_COMPARE,
    ST_WAIT,
    ST_DRIVE_B,
    ST_DECIDE,
    ST_STEP,
    ST_DONE
  } scan_state_e;

endpackage

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int DRIVE_CYCLES    = 4,
  parameter int DEBOUNCE_CYCLES = 10800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rowLast,
  input  logic       rowDiffers,
  output scan_ctrl_t ctrl,
  output logic       busy,
  output logic       done
);

  localparam int TMAX = (DRIVE_CYCLES > DEBOUNCE_CYCLES) ? DRIVE_CYCLES : DEBOUNCE_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] DRIVE_LAST = TW'(DRIVE_CYCLES - 1);
  localparam logic [TW-1:0] WAIT_LAST  = TW'(DEBOUNCE_CYCLES - 1);

  scan_state_e state, stateNext;
  logic [TW-1:0] timer, timerNext;

  always_comb begin
    stateNext = state;
    timerNext = timer;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) stateNext = ST_RESET;
      end
      ST_RESET: begin
        ctrl.rowReset = 1'b1;
        ctrl.clrFlag  = 1'b1;
        timerNext     = '0;
        stateNext     = ST_DRIVE_A;
      end
      ST_DRIVE_A: begin
        ctrl.driveOn = 1'b1;
        if (timer == DRIVE_LAST) begin
          ctrl.captureA = 1'b1;
          stateNext     = ST_COMPARE;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      ST_COMPARE: begin
        timerNext = '0;
        if (rowDiffers)   stateNext = ST_WAIT;
        else if (rowLast) stateNext = ST_DONE;
        else              stateNext = ST_STEP;
      end
      ST_WAIT: begin
        if (timer == WAIT_LAST) begin
          timerNext = '0;
          stateNext = ST_DRIVE_B;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      ST_DRIVE_B: begin
        ctrl.driveOn = 1'b1;
        if (timer == DRIVE_LAST) begin
          ctrl.captureB = 1'b1;
          stateNext     = ST_DECIDE;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      ST_DECIDE: begin
        ctrl.commit = 1'b1;
        stateNext   = rowLast ? ST_DONE : ST_STEP;
      end
      ST_STEP: begin
        ctrl.rowStep = 1'b1;
        timerNext    = '0;
        stateNext    = ST_DRIVE_A;
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      state <= stateNext;
      timer <= timerNext;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/kbd_scan_dp.sv
module kbd_scan_dp
  import kbd_scan_pkg::*;
#(
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 7,
  parameter int USED_COLS = 7,
  parameter int ROW_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  scan_ctrl_t          ctrl,
  input  logic [NUM_COLS-1:0] colsN,
  output logic [NUM_ROWS-1:0] rowDriveN,
  output logic                rowLast,
  output logic                rowDiffers,
  output logic                anyEvent,
  output logic                evtValid,
  output logic [ROW_W-1:0]    evtRow,
  output logic [NUM_COLS-1:0] evtMask,
  output logic [NUM_COLS-1:0] evtState
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  logic [NUM_COLS-1:0] colMask;
  logic [ROW_W-1:0]    rowSel;
  logic [NUM_COLS-1:0] readA, readB, sensed, mapEntry;
  logic [NUM_COLS-1:0] keyMap [NUM_ROWS];
  logic                readsAgree;

  // Column mask: bits at or above USED_COLS never count
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_mask
    assign colMask[c] = (c < USED_COLS);
  end

  // Row counter with separate clear and advance strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowSel <= '0;
    end else if (ctrl.rowReset) begin
      rowSel <= '0;
    end else if (ctrl.rowStep && rowSel != LAST_ROW) begin
      rowSel <= rowSel + 1'b1;
    end
  end

  assign rowLast = (rowSel == LAST_ROW);

  // Row drivers: low only while the sequencer holds a drive window
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_drive
    assign rowDriveN[r] = ~(ctrl.driveOn && rowSel == ROW_W'(r));
  end

  // Inverted, masked column capture: pressed key reads as 1
  assign sensed = ~colsN & colMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readA <= '0;
      readB <= '0;
    end else begin
      if (ctrl.captureA) readA <= sensed;
      if (ctrl.captureB) readB <= sensed;
    end
  end

  assign mapEntry   = keyMap[rowSel];
  assign rowDiffers = (readA != mapEntry);
  assign readsAgree = (readA == readB);

  // Stored key map, one register per row
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_map
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        keyMap[r] <= '0;
      end else if (ctrl.commit && readsAgree && rowSel == ROW_W'(r)) begin
        keyMap[r] <= readB;
      end
    end
  end

  // Event register and per-scan flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid <= 1'b0;
      evtRow   <= '0;
      evtMask  <= '0;
      evtState <= '0;
      anyEvent <= 1'b0;
    end else begin
      evtValid <= 1'b0;
      if (ctrl.clrFlag) anyEvent <= 1'b0;
      if (ctrl.commit && readsAgree) begin
        evtValid <= 1'b1;
        evtRow   <= rowSel;
        evtMask  <= readB ^ mapEntry;
        evtState <= readB;
        anyEvent <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
  import kbd_scan_pkg::*;
#(
  parameter int NUM_ROWS        = 8,
  parameter int NUM_COLS        = 7,
  parameter int USED_COLS       = 7,
  parameter int DRIVE_CYCLES    = 4,
  parameter int DEBOUNCE_CYCLES = 10800,
  localparam int ROW_W          = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [NUM_COLS-1:0] colsN,
  output logic [NUM_ROWS-1:0] rowDriveN,
  output logic                busy,
  output logic                done,
  output logic                keyEvent,
  output logic                evtValid,
  output logic [ROW_W-1:0]    evtRow,
  output logic [NUM_COLS-1:0] evtMask,
  output logic [NUM_COLS-1:0] evtState
);

  scan_ctrl_t ctrl;
  logic       rowLast, rowDiffers, anyEvent;

  kbd_scan_ctrl #(
    .DRIVE_CYCLES   (DRIVE_CYCLES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .rowLast   (rowLast),
    .rowDiffers(rowDiffers),
    .ctrl      (ctrl),
    .busy      (busy),
    .done      (done)
  );

  kbd_scan_dp #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .USED_COLS(USED_COLS),
    .ROW_W    (ROW_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .colsN     (colsN),
    .rowDriveN (rowDriveN),
    .rowLast   (rowLast),
    .rowDiffers(rowDiffers),
    .anyEvent  (anyEvent),
    .evtValid  (evtValid),
    .evtRow    (evtRow),
    .evtMask   (evtMask),
    .evtState  (evtState)
  );

  assign keyEvent = anyEvent;

endmodule

// File: rtl/kbd_scan_checker.sv
module kbd_scan_checker #(
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 7,
  parameter int USED_COLS = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [NUM_ROWS-1:0] rowDriveN,
  input logic                busy,
  input logic                done,
  input logic                evtValid,
  input logic [NUM_COLS-1:0] evtMask,
  input logic [NUM_COLS-1:0] evtState
);

  logic [NUM_COLS-1:0] unusedCols;
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_unused
    assign unusedCols[c] = (c >= USED_COLS);
  end

  p_drive_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~rowDriveN));

  p_idle_no_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (&rowDriveN));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  p_busy_needs_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  p_busy_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_event_in_scan_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (busy && evtMask != '0));

  p_event_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid);

  p_top_col_hidden_r9: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> ((evtMask | evtState) & unusedCols) == '0);

endmodule

bind kbd_matrix_scan kbd_scan_checker #(
  .NUM_ROWS (NUM_ROWS),
  .NUM_COLS (NUM_COLS),
  .USED_COLS(USED_COLS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .rowDriveN(rowDriveN),
  .busy     (busy),
  .done     (done),
  .evtValid (evtValid),
  .evtMask  (evtMask),
  .evtState (evtState)
);

// File: tb/test_kbd_matrix_scan.sv
`timescale 1ns/1ps
module test_kbd_matrix_scan;

  localparam int ROWS = 8;
  localparam int COLS = 7;
  localparam int DRV  = 3;
  localparam int DEB  = 20;
  localparam int BASE_LEN = 1 + ROWS*(DRV+1) + (ROWS-1) + 1;
  localparam int EXTRA    = DEB + DRV + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;

  // Main instance (seven columns)
  logic            start = 1'b0;
  logic [COLS-1:0] colsN;
  logic [ROWS-1:0] rowDriveN;
  logic            busy, done, keyEvent, evtValid;
  logic [2:0]      evtRow;
  logic [COLS-1:0] evtMask, evtState;

  kbd_matrix_scan #(.NUM_ROWS(ROWS), .NUM_COLS(COLS), .USED_COLS(7),
                    .DRIVE_CYCLES(DRV), .DEBOUNCE_CYCLES(DEB)) i_kbd_matrix_scan (
    .clk(clk), .rstN(rstN), .start(start), .colsN(colsN), .rowDriveN(rowDriveN),
    .busy(busy), .done(done), .keyEvent(keyEvent), .evtValid(evtValid),
    .evtRow(evtRow), .evtMask(evtMask), .evtState(evtState));

  // Six-column variant
  logic            start6 = 1'b0;
  logic [COLS-1:0] cols6N;
  logic [ROWS-1:0] rowDrive6N;
  logic            busy6, done6, keyEvent6, evtValid6;
  logic [2:0]      evtRow6;
  logic [COLS-1:0] evtMask6, evtState6;

  kbd_matrix_scan #(.NUM_ROWS(ROWS), .NUM_COLS(COLS), .USED_COLS(6),
                    .DRIVE_CYCLES(DRV), .DEBOUNCE_CYCLES(DEB)) i_kbd_matrix_scan_six (
    .clk(clk), .rstN(rstN), .start(start6), .colsN(cols6N), .rowDriveN(rowDrive6N),
    .busy(busy6), .done(done6), .keyEvent(keyEvent6), .evtValid(evtValid6),
    .evtRow(evtRow6), .evtMask(evtMask6), .evtState(evtState6));

  // Key matrix model
  logic [COLS-1:0] keys  [ROWS];
  logic [COLS-1:0] keys6 [ROWS];
  logic [COLS-1:0] model [ROWS];
  int              winCnt [ROWS];
  logic            bounceOn = 1'b0;
  int              bounceRow = 0;
  logic [COLS-1:0] bounceMask = '0;

  always_comb begin
    colsN = '1;
    for (int r = 0; r < ROWS; r++)
      if (!rowDriveN[r])
        colsN = ~(keys[r] ^ ((bounceOn && r == bounceRow && winCnt[r] >= 2) ? bounceMask : '0));
  end

  always_comb begin
    cols6N = '1;
    for (int r = 0; r < ROWS; r++)
      if (!rowDrive6N[r]) cols6N = ~keys6[r];
  end

  // Window and event monitor
  logic [ROWS-1:0] prevDrive = '1;
  int lastRow = -1;
  int orderErr = 0;
  int evN = 0;
  int ev6N = 0;
  logic [2:0]      evRowLog   [ROWS];
  logic [COLS-1:0] evMaskLog  [ROWS];
  logic [COLS-1:0] evStateLog [ROWS];
  logic [COLS-1:0] ev6Mask = '0;

  always @(negedge clk) begin
    if (rowDriveN != '1 && prevDrive == '1) begin
      for (int r = 0; r < ROWS; r++) begin
        if (!rowDriveN[r]) begin
          winCnt[r] = winCnt[r] + 1;
          if (r < lastRow) orderErr = orderErr + 1;
          lastRow = r;
        end
      end
    end
    prevDrive = rowDriveN;
    if (evtValid) begin
      if (evN < ROWS) begin
        evRowLog[evN]   = evtRow;
        evMaskLog[evN]  = evtMask;
        evStateLog[evN] = evtState;
      end
      evN = evN + 1;
    end
    if (evtValid6) begin
      ev6N = ev6N + 1;
      ev6Mask = evtMask6;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One scan on the main instance, with optional bounce and a start during busy
  task automatic runScan(input bit bounce, input int bRow, input logic [COLS-1:0] bMask,
                         input bit midStart);
    int              nDiff = 0;
    int              nExp = 0;
    int              cycles = 0;
    logic [2:0]      expRow   [ROWS];
    logic [COLS-1:0] expMask  [ROWS];
    logic [COLS-1:0] expState [ROWS];
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] seen;
      logic [COLS-1:0] diff;
      seen = keys[r];
      diff = seen ^ model[r];
      if (diff != '0) begin
        nDiff++;
        if (!(bounce && r == bRow && bMask != '0)) begin
          expRow[nExp] = 3'(r);
          expMask[nExp] = diff;
          expState[nExp] = seen;
          nExp++;
          model[r] = seen;
        end
      end
    end
    for (int r = 0; r < ROWS; r++) winCnt[r] = 0;
    bounceOn = bounce; bounceRow = bRow; bounceMask = bMask;
    lastRow = -1; orderErr = 0; evN = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (1) begin
      cycles++;
      if (done || cycles > 5000) break;
      if (midStart && cycles == 5) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R4", "scan length", cycles, BASE_LEN + nDiff*EXTRA);
    check("R7", "keyEvent at done", {31'd0, keyEvent}, {31'd0, nExp > 0});
    @(negedge clk);
    check("R7", "done one cycle", {30'd0, done, busy}, 32'd0);
    check("R3", "row order", orderErr, 0);
    check("R3", "last row driven", lastRow, ROWS-1);
    check("R5", "event count", evN, nExp);
    for (int i = 0; i < nExp && i < evN; i++) begin
      check("R5", "event row", evRowLog[i], expRow[i]);
      check("R2", "event mask", evMaskLog[i], expMask[i]);
      check("R2", "event state", evStateLog[i], expState[i]);
    end
    bounceOn = 1'b0;
  endtask

  task automatic runSix(input int expCount, input logic [COLS-1:0] expMaskIn);
    int cycles = 0;
    ev6N = 0;
    @(negedge clk) start6 = 1'b1;
    @(negedge clk) start6 = 1'b0;
    while (!done6 && cycles < 5000) begin
      cycles++;
      @(negedge clk);
    end
    check("R9", "six-col keyEvent", {31'd0, keyEvent6}, {31'd0, expCount > 0});
    @(negedge clk);
    check("R9", "six-col event count", ev6N, expCount);
    if (expCount > 0) check("R9", "six-col mask", ev6Mask, expMaskIn);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < ROWS; r++) begin
      keys[r] = '0; keys6[r] = '0; model[r] = '0; winCnt[r] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy/done/evt in reset", {29'd0, busy, done, evtValid}, 32'd0);
    check("R1", "rows idle in reset", rowDriveN, {ROWS{1'b1}});
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "rows idle after reset", rowDriveN, {ROWS{1'b1}});
    // R1/R4: map starts empty, so an idle matrix gives no event
    runScan(0, 0, '0, 0);
    // R2/R5: corner keys
    keys[0] = 7'h01; keys[7] = 7'h40;
    runScan(0, 0, '0, 0);
    // R5: same keys again, map updated, no event
    runScan(0, 0, '0, 0);
    // R6: bounce on a changed row discards the change
    keys[3] = 7'h15;
    runScan(1, 3, 7'h04, 0);
    // R6: clean rescan now reports it
    runScan(0, 0, '0, 0);
    // R8: start while busy with a change in flight
    keys[5] = 7'h2A;
    runScan(0, 0, '0, 1);
    // R2: release everything
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
    runScan(0, 0, '0, 0);
    // Random scans
    for (int n = 0; n < 30; n++) begin
      bit b, m;
      for (int r = 0; r < ROWS; r++)
        if (($urandom % 4) == 0) keys[r] = 7'($urandom);
      b = (($urandom % 3) == 0);
      m = (($urandom % 4) == 0);
      runScan(b, int'($urandom % ROWS), 7'($urandom | 1), m);
    end
    // R9: six-column variant ignores the top column
    keys6[3] = 7'h40;
    runSix(0, '0);
    keys6[3] = 7'h41;
    runSix(1, 7'h01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule